// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers requests from a parameterised set of interrupt sources and drives one active-low request line to a processor. Each source has its own priority, trigger type, enable bit and 32-bit vector word. The controller tracks a current priority level. It raises the request line only while an enabled, pending source sits strictly above that level.

The processor claims work by reading the claim register. The read returns the vector word of the best candidate. In the same cycle it pushes the old level onto an internal stack, moves the level up to the winner's priority and clears an edge-type request. Requests of higher priority can then assert the line again, which gives nested service. A write to the end-of-service register pops the stack.

In protect mode the claim read has no side effects. It returns the vector and remembers the winner. The push and the acknowledge wait for a later write to the claim register, so that a debugger can inspect the vector without disturbing the controller.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request line `irqN` is high, every source is disabled, the level is idle (below every priority) and all stored configuration reads as zero.
- R2: A claim selects the enabled, pending source with the largest 3-bit priority (7 highest). When priorities tie, the smaller source number wins. The claim returns that source's vector word.
- R3: `irqN` is low exactly when some enabled, pending source has a priority strictly greater than the current level. A level-type source counts while its input is high. An edge-type source counts from the clock edge that first samples its input high until its request is acknowledged.
- R4: In normal mode a claim read that finds a candidate pushes the current level, sets the level to the winner's priority and so releases `irqN` unless a strictly higher request is waiting.
- R5: An acknowledge clears the pending request of an edge-type winner. A level-type winner stays pending for as long as its input is high.
- R6: A claim read that finds no candidate above the current level returns the spurious vector and changes neither the level nor the stack.
- R7: A write to the end-of-service register restores the level saved by the most recent push. The stack holds 8 levels. A write made while the stack is empty leaves the level idle.
- R8: While a claimed source is being served, a request of strictly higher priority asserts `irqN` again, and its claim nests above the current one.
- R9: In protect mode (mode bit 0 = 1) a claim read returns the winner's vector and remembers the winner, but changes no state. A later write to the claim register does the push, the level update and the edge clear for the remembered winner.
- R10: In normal mode a write to the claim register has no effect.
- R11: Enable-set and enable-clear writes set or clear, per set data bit, the enable of the matching source. A disabled source never asserts `irqN` and is never claimed.
- R12: Word addresses: vector word of source n at n, priority of source n at 32+n, enable set at 64 (it reads back the enable mask), enable clear at 65, trigger types at 66 (bit n = 1 makes source n edge-type; readable), spurious vector at 67, mode at 68 (bit 0 = protect; readable), claim at 69, end-of-service at 70. Read data is valid in the same cycle as the read. Writes and claim side effects take effect at the clock edge that ends the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 7 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while the read is presented |
| srcIn | input | 32 | Interrupt source inputs, active high |
| irqN | output | 1 | Active-low interrupt request to the processor |

## Verification
Read data is combinational, so the bench drives each access on a falling edge and samples `busRdata` 1 ns later, inside the same cycle. Claim, acknowledge, stack and configuration updates land on the next rising edge, so every check of `irqN` that follows an access waits for the next falling edge. A level input reaches `irqN` without a register. An edge input needs one rising edge to set its pending flag, so the bench always waits one falling edge after moving an input before it samples the line. Expected vectors and winners are computed arithmetically from the source number and from swept priority pairs.

// File: rtl/pic_pkg.sv
package pic_pkg;

  // Per-cycle strobes decoded from the register bus
  typedef struct packed {
    logic vecWe;     // write vector word of the indexed source
    logic prioWe;    // write priority of the indexed source
    logic enSet;     // set enables for ones in write data
    logic enClr;     // clear enables for ones in write data
    logic trigWe;    // write the trigger-type mask
    logic spurWe;    // write the spurious vector
    logic claimNow;  // normal-mode claim read: select and acknowledge
    logic memoNow;   // protect-mode claim read: select and remember
    logic ackHeld;   // protect-mode claim write: acknowledge remembered winner
    logic eoi;       // end-of-service: pop the level stack
  } strobe_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CLAIM,
    RD_ENABLE,
    RD_TRIG,
    RD_SPUR,
    RD_MODE
  } rd_sel_e;

endpackage

// File: rtl/pic_control.sv
module pic_control
  import pic_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [IDX_W+1:0]  busAddr,
  input  logic              modeBit,
  output strobe_t           stb,
  output rd_sel_e           rdSel,
  output logic              protectMode
);

  localparam int ADDR_W = IDX_W + 2;
  localparam logic [IDX_W-1:0] OFF_ENSET = IDX_W'(0);
  localparam logic [IDX_W-1:0] OFF_ENCLR = IDX_W'(1);
  localparam logic [IDX_W-1:0] OFF_TRIG  = IDX_W'(2);
  localparam logic [IDX_W-1:0] OFF_SPUR  = IDX_W'(3);
  localparam logic [IDX_W-1:0] OFF_MODE  = IDX_W'(4);
  localparam logic [IDX_W-1:0] OFF_CLAIM = IDX_W'(5);
  localparam logic [IDX_W-1:0] OFF_EOI   = IDX_W'(6);

  logic [1:0]       region;
  logic [IDX_W-1:0] off;
  logic             isWr, isRd, isCtrl;

  assign region = busAddr[ADDR_W-1:IDX_W];
  assign off    = busAddr[IDX_W-1:0];
  assign isWr   = busSel & busWr;
  assign isRd   = busSel & ~busWr;
  assign isCtrl = region[1];

  always_comb begin
    stb          = '0;
    stb.vecWe    = isWr && (region == 2'b00);
    stb.prioWe   = isWr && (region == 2'b01);
    stb.enSet    = isWr && isCtrl && (off == OFF_ENSET);
    stb.enClr    = isWr && isCtrl && (off == OFF_ENCLR);
    stb.trigWe   = isWr && isCtrl && (off == OFF_TRIG);
    stb.spurWe   = isWr && isCtrl && (off == OFF_SPUR);
    stb.claimNow = isRd && isCtrl && (off == OFF_CLAIM) && !protectMode;
    stb.memoNow  = isRd && isCtrl && (off == OFF_CLAIM) && protectMode;
    stb.ackHeld  = isWr && isCtrl && (off == OFF_CLAIM) && protectMode;
    stb.eoi      = isWr && isCtrl && (off == OFF_EOI);
  end

  always_comb begin
    rdSel = RD_NONE;
    if (isRd && isCtrl) begin
      case (off)
        OFF_ENSET: rdSel = RD_ENABLE;
        OFF_TRIG:  rdSel = RD_TRIG;
        OFF_SPUR:  rdSel = RD_SPUR;
        OFF_MODE:  rdSel = RD_MODE;
        OFF_CLAIM: rdSel = RD_CLAIM;
        default:   rdSel = RD_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) protectMode <= 1'b0;
    else if (isWr && isCtrl && (off == OFF_MODE)) protectMode <= modeBit;
  end

  // R9
  mode_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isWr && isCtrl && (off == OFF_MODE)) |=> (protectMode == $past(modeBit)));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(isWr && isCtrl && (off == OFF_MODE)) |=> $stable(protectMode));

endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int PRIO_W      = 3,
  parameter int STACK_DEPTH = 8,
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  rd_sel_e            rdSel,
  input  logic               protectMode,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [DATA_W-1:0]  rdata,
  output logic               irqN
);

  localparam int LVL_W = PRIO_W + 1;             // 0 = idle, p+1 = priority p
  localparam int SP_W  = $clog2(STACK_DEPTH + 1);
  localparam int ST_IW = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;

  logic [DATA_W-1:0]  vecMem   [NUM_SRC];
  logic [PRIO_W-1:0]  prioMem  [NUM_SRC];
  logic [LVL_W-1:0]   stackMem [STACK_DEPTH];
  logic [NUM_SRC-1:0] enMask, edgeMask, prevIn, edgeFlag;
  logic [DATA_W-1:0]  spurVec;
  logic [SP_W-1:0]    sp, spDec;
  logic [LVL_W-1:0]   curLevel, heldLevel;
  logic [IDX_W-1:0]   heldIdx;
  logic               heldValid;

  logic [NUM_SRC-1:0] rise, pending, eligible, clrMask;
  logic               bestValid, above, doAck;
  logic [IDX_W-1:0]   bestIdx, ackIdx;
  logic [PRIO_W-1:0]  bestPrio;
  logic [LVL_W-1:0]   bestLevel, ackLevel;
  logic [DATA_W-1:0]  claimVec;

  assign rise     = srcIn & ~prevIn;
  assign pending  = (edgeMask & edgeFlag) | (~edgeMask & srcIn);
  assign eligible = pending & enMask;

  // Priority resolver: scan downwards so that ties go to the lower number
  always_comb begin
    bestValid = 1'b0;
    bestIdx   = '0;
    bestPrio  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i] && (!bestValid || prioMem[i] >= bestPrio)) begin
        bestValid = 1'b1;
        bestIdx   = IDX_W'(i);
        bestPrio  = prioMem[i];
      end
    end
  end

  assign bestLevel = {1'b0, bestPrio} + LVL_W'(1);
  assign above     = bestValid && (bestLevel > curLevel);
  assign irqN      = ~above;
  assign claimVec  = above ? vecMem[bestIdx] : spurVec;

  assign spDec    = sp - SP_W'(1);
  assign doAck    = ((stb.claimNow && above) || (stb.ackHeld && heldValid))
                    && (sp < SP_W'(STACK_DEPTH));
  assign ackIdx   = stb.claimNow ? bestIdx : heldIdx;
  assign ackLevel = stb.claimNow ? bestLevel : heldLevel;
  assign clrMask  = doAck ? (NUM_SRC'(1) << ackIdx) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        vecMem[i]  <= '0;
        prioMem[i] <= '0;
      end
      for (int j = 0; j < STACK_DEPTH; j++) stackMem[j] <= '0;
      enMask    <= '0;
      edgeMask  <= '0;
      prevIn    <= '0;
      edgeFlag  <= '0;
      spurVec   <= '0;
      sp        <= '0;
      curLevel  <= '0;
      heldValid <= 1'b0;
      heldIdx   <= '0;
      heldLevel <= '0;
    end else begin
      prevIn   <= srcIn;
      edgeFlag <= ((edgeFlag & ~clrMask) | rise) & edgeMask;
      if (stb.vecWe)  vecMem[cfgIdx]  <= wdata;
      if (stb.prioWe) prioMem[cfgIdx] <= wdata[PRIO_W-1:0];
      if (stb.enSet)  enMask   <= enMask | wdata[NUM_SRC-1:0];
      if (stb.enClr)  enMask   <= enMask & ~wdata[NUM_SRC-1:0];
      if (stb.trigWe) edgeMask <= wdata[NUM_SRC-1:0];
      if (stb.spurWe) spurVec  <= wdata;

      if (stb.memoNow) begin
        heldValid <= above;
        heldIdx   <= bestIdx;
        heldLevel <= bestLevel;
      end else if (doAck) begin
        heldValid <= 1'b0;
      end

      if (doAck) begin
        stackMem[sp[ST_IW-1:0]] <= curLevel;
        sp       <= sp + SP_W'(1);
        curLevel <= ackLevel;
      end else if (stb.eoi) begin
        if (sp == '0) begin
          curLevel <= '0;
        end else begin
          curLevel <= stackMem[spDec[ST_IW-1:0]];
          sp       <= spDec;
        end
      end
    end
  end

  always_comb begin
    case (rdSel)
      RD_CLAIM:  rdata = claimVec;
      RD_ENABLE: rdata = DATA_W'(enMask);
      RD_TRIG:   rdata = DATA_W'(edgeMask);
      RD_SPUR:   rdata = spurVec;
      RD_MODE:   rdata = DATA_W'(protectMode);
      default:   rdata = '0;
    endcase
  end

  // R4
  ack_raises_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    doAck |=> (curLevel > $past(curLevel)));

  // R6
  spurious_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.claimNow && !above) |=> ($stable(curLevel) && $stable(sp)));

  // R7
  stack_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    sp <= SP_W'(STACK_DEPTH));

  // R10
  stack_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.claimNow && !stb.ackHeld && !stb.eoi) |=> $stable(sp));

  // R9
  memo_no_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.memoNow |=> ($stable(sp) && $stable(curLevel)));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int PRIO_W      = 3,
  parameter int STACK_DEPTH = 8,
  parameter int DATA_W      = 32,
  localparam int IDX_W      = $clog2(NUM_SRC),
  localparam int ADDR_W     = IDX_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqN
);

  strobe_t stb;
  rd_sel_e rdSel;
  logic    protectMode;

  pic_control #(.IDX_W(IDX_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .busSel      (busSel),
    .busWr       (busWr),
    .busAddr     (busAddr),
    .modeBit     (busWdata[0]),
    .stb         (stb),
    .rdSel       (rdSel),
    .protectMode (protectMode)
  );

  pic_datapath #(
    .NUM_SRC     (NUM_SRC),
    .PRIO_W      (PRIO_W),
    .STACK_DEPTH (STACK_DEPTH),
    .DATA_W      (DATA_W),
    .IDX_W       (IDX_W)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .rdSel       (rdSel),
    .protectMode (protectMode),
    .cfgIdx      (busAddr[IDX_W-1:0]),
    .wdata       (busWdata),
    .srcIn       (srcIn),
    .rdata       (busRdata),
    .irqN        (irqN)
  );

endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;

  localparam int A_PRIO  = 32;
  localparam int A_ENSET = 64;
  localparam int A_ENCLR = 65;
  localparam int A_TRIG  = 66;
  localparam int A_SPUR  = 67;
  localparam int A_MODE  = 68;
  localparam int A_CLAIM = 69;
  localparam int A_EOI   = 70;
  localparam logic [31:0] SPUR_V = 32'h5A5A_0F0F;
  localparam logic [31:0] EDGE_M = 32'hAAAA_AAAA;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busSel, busWr;
  logic [6:0]  busAddr;
  logic [31:0] busWdata, busRdata;
  logic [31:0] src;
  logic        irqN;
  logic [31:0] d;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .srcIn(src), .irqN(irqN)
  );

  function automatic logic [31:0] vecOf(input int s);
    return 32'hC0DE_0000 + 32'(s * 4);
  endfunction

  function automatic logic [31:0] prioOf(input int s);
    return 32'((s * 5 + 3) % 8);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input int a, input logic [31:0] v);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = 7'(a); busWdata = v;
    @(posedge clk); #1;
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input int a, output logic [31:0] v);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = 7'(a);
    #1 v = busRdata;
    @(posedge clk); #1;
    busSel = 1'b0;
  endtask

  task automatic irqIs(input string tag, input logic exp);
    @(negedge clk);
    chk(tag, {31'b0, irqN}, {31'b0, exp});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; busSel = 1'b0; busWr = 1'b0; busAddr = '0; busWdata = '0; src = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    irqIs("R1 irq idle after reset", 1'b1);
    busRead(A_ENSET, d); chk("R1 enables cleared", d, 32'h0);
    busRead(A_MODE, d);  chk("R1 mode cleared", d, 32'h0);

    // R12 configuration
    for (int s = 0; s < 32; s++) begin
      busWrite(s, vecOf(s));
      busWrite(A_PRIO + s, prioOf(s));
    end
    busWrite(A_TRIG, EDGE_M);
    busWrite(A_SPUR, SPUR_V);
    busRead(A_TRIG, d); chk("R12 trigger mask readback", d, EDGE_M);
    busRead(A_SPUR, d); chk("R12 spurious readback", d, SPUR_V);
    busRead(A_CLAIM, d); chk("R6 idle claim spurious", d, SPUR_V);

    // Per-source sweep: odd sources edge, even sources level
    for (int s = 0; s < 32; s++) begin
      busWrite(A_ENSET, 32'(1) << s);
      busRead(A_ENSET, d); chk("R11 enable set", d, 32'(1) << s);
      @(negedge clk); src[s] = 1'b1;
      irqIs("R3 single request asserts", 1'b0);
      busRead(A_CLAIM, d); chk("R2 vector of single source", d, vecOf(s));
      irqIs("R4 claim releases irq", 1'b1);
      if (s % 2 == 1) begin
        src[s] = 1'b0;
        busWrite(A_EOI, 0);
        irqIs("R5 edge request cleared", 1'b1);
      end else begin
        busWrite(A_EOI, 0);
        irqIs("R5 level request stays", 1'b0);
        src[s] = 1'b0;
        irqIs("R3 level released", 1'b1);
      end
      busWrite(A_ENCLR, 32'(1) << s);
    end

    // Priority pair sweep on level sources 2 and 4
    busWrite(A_ENSET, (32'(1) << 2) | (32'(1) << 4));
    @(negedge clk); src[2] = 1'b1; src[4] = 1'b1;
    for (int pa = 0; pa < 8; pa++) begin
      for (int pb = 0; pb < 8; pb++) begin
        busWrite(A_PRIO + 2, 32'(pa));
        busWrite(A_PRIO + 4, 32'(pb));
        busRead(A_CLAIM, d);
        chk("R2 pair winner and tie", d, vecOf((pa >= pb) ? 2 : 4));
        irqIs("R3 loser not above", 1'b1);
        busWrite(A_EOI, 0);
      end
    end
    @(negedge clk); src[2] = 1'b0; src[4] = 1'b0;
    busWrite(A_ENCLR, (32'(1) << 2) | (32'(1) << 4));

    // R8 nesting with sources 6 (prio 2), 8 and 10 (prio 5), all level
    busWrite(A_PRIO + 6, 2);
    busWrite(A_PRIO + 8, 5);
    busWrite(A_PRIO + 10, 5);
    busWrite(A_ENSET, (32'(1) << 6) | (32'(1) << 8) | (32'(1) << 10));
    @(negedge clk); src[6] = 1'b1;
    busRead(A_CLAIM, d); chk("R8 outer claim", d, vecOf(6));
    irqIs("R4 outer released", 1'b1);
    src[10] = 1'b1;
    irqIs("R8 higher request reasserts", 1'b0);
    busRead(A_CLAIM, d); chk("R8 nested claim", d, vecOf(10));
    irqIs("R4 nested released", 1'b1);
    src[8] = 1'b1;
    irqIs("R3 equal priority not above", 1'b1);
    busWrite(A_EOI, 0);
    irqIs("R7 pop back to outer level", 1'b0);
    busRead(A_CLAIM, d); chk("R2 tie at priority 5", d, vecOf(8));
    @(negedge clk); src[8] = 1'b0; src[10] = 1'b0;
    busWrite(A_EOI, 0);
    irqIs("R7 outer level restored", 1'b1);
    busRead(A_CLAIM, d); chk("R6 spurious while serving", d, SPUR_V);
    busWrite(A_EOI, 0);
    irqIs("R6 spurious pushed nothing", 1'b0);
    src[6] = 1'b0;
    irqIs("R3 source 6 released", 1'b1);
    busWrite(A_EOI, 0);
    @(negedge clk); src[6] = 1'b1;
    irqIs("R7 empty pop leaves idle", 1'b0);
    busRead(A_CLAIM, d); chk("R7 claim after empty pop", d, vecOf(6));

    // R10 normal-mode write to claim register
    busWrite(A_EOI, 0);
    irqIs("R10 pending before write", 1'b0);
    busWrite(A_CLAIM, 32'hFFFF_FFFF);
    irqIs("R10 write leaves irq", 1'b0);
    busRead(A_CLAIM, d); chk("R10 write pushed nothing", d, vecOf(6));
    @(negedge clk); src[6] = 1'b0;
    busWrite(A_EOI, 0);
    busWrite(A_ENCLR, (32'(1) << 6) | (32'(1) << 8) | (32'(1) << 10));

    // R9 protect mode with edge source 13, priority 4
    busWrite(A_MODE, 1);
    busRead(A_MODE, d); chk("R9 mode readback", d, 32'h1);
    busWrite(A_PRIO + 13, 4);
    busWrite(A_ENSET, 32'(1) << 13);
    @(negedge clk); src[13] = 1'b1;
    irqIs("R9 edge request asserts", 1'b0);
    src[13] = 1'b0;
    busRead(A_CLAIM, d); chk("R9 protect read vector", d, vecOf(13));
    irqIs("R9 read keeps irq", 1'b0);
    busRead(A_CLAIM, d); chk("R9 second read same vector", d, vecOf(13));
    busWrite(A_CLAIM, 0);
    irqIs("R9 write acknowledges", 1'b1);
    busWrite(A_EOI, 0);
    irqIs("R9 edge cleared by write", 1'b1);
    busWrite(A_MODE, 0);
    busWrite(A_ENCLR, 32'(1) << 13);

    // R11 disabled source ignored
    busWrite(A_ENSET, 32'(1) << 6);
    busWrite(A_ENCLR, 32'(1) << 6);
    busRead(A_ENSET, d); chk("R11 enable cleared", d, 32'h0);
    @(negedge clk); src[6] = 1'b1;
    irqIs("R11 disabled no irq", 1'b1);
    busRead(A_CLAIM, d); chk("R11 disabled not claimed", d, SPUR_V);
    @(negedge clk); src[6] = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule